// File: doc/BRIEF.md
# Synchronous FIFO with Selectable Read Presentation

This block is a single-clock FIFO built on an inferred register array. A parameter chooses how its read port presents data. In fall-through mode, the oldest stored word moves into the output register on its own. The output then shows that word with the valid flag raised, and a read request means "this word is taken, show the next one". In standard mode, nothing reaches the output until a read request is sampled. Each accepted request fetches one word, which appears one cycle later.

The two modes differ only when the FIFO runs empty. Once words are flowing, each accepted read moves the read side on by exactly one word in either mode. Write requests while full and read requests with nothing to deliver are dropped without side effects. A synchronous reset discards all contents.

Top module: `fifo_rdmode`

## Requirements
- R1: In fall-through mode (MODE=1), a word written into an empty FIFO appears on `rd_data` with `rd_valid` high and `empty` low after the second rising edge following the write cycle, with `rd_en` held low.
- R2: In standard mode (MODE=0), no word reaches the output without a read request. `rd_valid` stays low after writes alone, while `empty` goes low as soon as a word is stored.
- R3: In standard mode, `rd_en` sampled high while `empty` is low makes `rd_valid` high for exactly the following cycle, with `rd_data` equal to the oldest stored word.
- R4: In fall-through mode, `rd_en` sampled while `rd_valid` is high consumes the shown word. In the next cycle the next stored word is shown, or `rd_valid` goes low if nothing is stored.
- R5: In both modes, words leave in the order they were written.
- R6: In fall-through mode, `empty` is always the inverse of `rd_valid`. In standard mode, `empty` is high exactly when the storage array holds no word.
- R7: `full` is high when the storage array holds DEPTH words. A write while `full` is high is dropped: no stored word is overwritten and no extra word is delivered.
- R8: A read request when nothing can be delivered (standard: `empty` high; fall-through: `rd_valid` low) is ignored. No valid data is produced, and later traffic is unaffected.
- R9: A write and an accepted read in the same cycle, with the FIFO neither empty nor full, leave `full` and `empty` unchanged and keep both data streams intact.
- R10: A synchronous reset (`rst` high at a rising edge) leaves `empty` high, `full` low and `rd_valid` low, and discards all stored words.
- R11: In fall-through mode, the shown word and `rd_valid` stay stable while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request (fetch in standard mode, take-and-advance in fall-through mode) |
| rd_data | output | DATA_W | Output register holding the presented word |
| rd_valid | output | 1 | `rd_data` holds a delivered word |
| empty | output | 1 | No word available (see R6) |
| full | output | 1 | Storage array holds DEPTH words |

## Verification
In a single cycle, a write can be accepted into the array at the same time as a read pops a word from it. In fall-through mode, that read also consumes the shown word and refills the output register. The bench first loads two words, then holds `wr_en` and `rd_en` together for one cycle in each mode. It then requires the flags to stay unchanged, the correct next word to appear at once, and the drained sequence to come out complete and in write order. The full case is tested separately: the bench fills the array, offers one more write, and confirms that this extra word never appears during the drain.

// File: rtl/fifo_rdmode_pkg.sv
package fifo_rdmode_pkg;

    typedef enum logic {
        RDM_STANDARD = 1'b0,
        RDM_FALLTHRU = 1'b1
    } rd_mode_e;

endpackage

// File: rtl/fifo_store.sv
module fifo_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Storage carries no reset; the pointers alone decide what is valid.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  logic          pop,
    output logic          push,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic          stor_empty,
    output logic          full
);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
    } ctrl_t;

    ctrl_t st_q, st_d;
    logic  pop_ok;

    function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        full       = (st_q.count == CW'(DEPTH));
        stor_empty = (st_q.count == '0);
        push       = wr_req && !full;
        pop_ok     = pop && !stor_empty;
        st_d       = st_q;
        if (push) begin
            st_d.wr_ptr = adv(st_q.wr_ptr);
        end
        if (pop_ok) begin
            st_d.rd_ptr = adv(st_q.rd_ptr);
        end
        case ({push, pop_ok})
            2'b10:   st_d.count = st_q.count + CW'(1);
            2'b01:   st_d.count = st_q.count - CW'(1);
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ptr = st_q.wr_ptr;
    assign rd_ptr = st_q.rd_ptr;

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.count <= CW'(DEPTH));

    // R7
    full_write_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (full && wr_req) |=> $stable(st_q.wr_ptr));

    // R8
    empty_pop_drop_chk: assert property (@(posedge clk) disable iff (rst)
        stor_empty |=> $stable(st_q.rd_ptr));

    // R9
    push_pop_level_chk: assert property (@(posedge clk) disable iff (rst)
        (push && pop) |=> $stable(st_q.count));

endmodule

// File: rtl/fifo_outstage.sv
module fifo_outstage
    import fifo_rdmode_pkg::*;
#(
    parameter int       DATA_W = 8,
    parameter rd_mode_e MODE   = RDM_FALLTHRU
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              stor_empty,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              empty
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } out_t;

    out_t os_q, os_d;

    generate
        if (MODE == RDM_FALLTHRU) begin : g_fallthru
            // Refill whenever the output register is free or being taken.
            always_comb begin
                pop  = !stor_empty && (!os_q.valid || rd_en);
                os_d = os_q;
                if (pop) begin
                    os_d.data  = mem_rdata;
                    os_d.valid = 1'b1;
                end else if (rd_en && os_q.valid) begin
                    os_d.valid = 1'b0;
                end
            end
            assign empty = !os_q.valid;

            // R11
            hold_word_chk: assert property (@(posedge clk) disable iff (rst)
                (os_q.valid && !rd_en) |=> (os_q.valid && $stable(os_q.data)));

            // R4
            last_take_chk: assert property (@(posedge clk) disable iff (rst)
                (os_q.valid && rd_en && stor_empty) |=> !os_q.valid);
        end else begin : g_standard
            // Each accepted request fetches exactly one word.
            always_comb begin
                pop        = rd_en && !stor_empty;
                os_d       = os_q;
                os_d.valid = pop;
                if (pop) begin
                    os_d.data = mem_rdata;
                end
            end
            assign empty = stor_empty;

            // R3
            fetch_latency_chk: assert property (@(posedge clk) disable iff (rst)
                (rd_en && !stor_empty) |=> (os_q.valid && os_q.data == $past(mem_rdata)));

            // R2
            no_unrequested_chk: assert property (@(posedge clk) disable iff (rst)
                !rd_en |=> !os_q.valid);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            os_q <= '0;
        end else begin
            os_q <= os_d;
        end
    end

    assign rd_data  = os_q.data;
    assign rd_valid = os_q.valid;

    // R10
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> !os_q.valid);

endmodule

// File: rtl/fifo_rdmode.sv
module fifo_rdmode
    import fifo_rdmode_pkg::*;
#(
    parameter int       DATA_W = 8,
    parameter int       DEPTH  = 16,
    parameter rd_mode_e MODE   = RDM_FALLTHRU,
    localparam int      AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              empty,
    output logic              full
);

    logic              push_w;
    logic              pop_w;
    logic              stor_empty_w;
    logic [AW-1:0]     wr_ptr_w;
    logic [AW-1:0]     rd_ptr_w;
    logic [DATA_W-1:0] mem_rdata_w;

    fifo_ctrl #(
        .DEPTH (DEPTH)
    ) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .wr_req     (wr_en),
        .pop        (pop_w),
        .push       (push_w),
        .wr_ptr     (wr_ptr_w),
        .rd_ptr     (rd_ptr_w),
        .stor_empty (stor_empty_w),
        .full       (full)
    );

    fifo_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) store_i (
        .clk   (clk),
        .we    (push_w),
        .waddr (wr_ptr_w),
        .wdata (wr_data),
        .raddr (rd_ptr_w),
        .rdata (mem_rdata_w)
    );

    fifo_outstage #(
        .DATA_W (DATA_W),
        .MODE   (MODE)
    ) out_i (
        .clk        (clk),
        .rst        (rst),
        .rd_en      (rd_en),
        .stor_empty (stor_empty_w),
        .mem_rdata  (mem_rdata_w),
        .pop        (pop_w),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .empty      (empty)
    );

endmodule

// File: tb/fifo_rdmode_tb_top.sv
`timescale 1ns/1ps
module fifo_rdmode_tb_top;
    import fifo_rdmode_pkg::*;

    localparam int DW = 8;
    localparam int DP = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          f_wr = 1'b0, f_rd = 1'b0;
    logic [DW-1:0] f_wd = '0;
    logic [DW-1:0] f_q;
    logic          f_valid, f_empty, f_full;

    logic          s_wr = 1'b0, s_rd = 1'b0;
    logic [DW-1:0] s_wd = '0;
    logic [DW-1:0] s_q;
    logic          s_valid, s_empty, s_full;

    int  n_total = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    fifo_rdmode #(.DATA_W(DW), .DEPTH(DP), .MODE(RDM_FALLTHRU)) dut_i (
        .clk(clk), .rst(rst), .wr_en(f_wr), .wr_data(f_wd), .rd_en(f_rd),
        .rd_data(f_q), .rd_valid(f_valid), .empty(f_empty), .full(f_full));

    fifo_rdmode #(.DATA_W(DW), .DEPTH(DP), .MODE(RDM_STANDARD)) dut_std_i (
        .clk(clk), .rst(rst), .wr_en(s_wr), .wr_data(s_wd), .rd_en(s_rd),
        .rd_data(s_q), .rd_valid(s_valid), .empty(s_empty), .full(s_full));

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Check a shown word in fall-through mode, then take it.
    task automatic f_take(input string req, input logic [DW-1:0] exp);
        chk(req, {f_valid, f_q}, {1'b1, exp});
        f_rd = 1'b1; tick(); f_rd = 1'b0;
    endtask

    // Fetch one word in standard mode and check it.
    task automatic s_fetch(input string req, input logic [DW-1:0] exp);
        s_rd = 1'b1; tick(); s_rd = 1'b0;
        chk(req, {s_valid, s_q}, {1'b1, exp});
    endtask

    task automatic t_reset_state();
        chk("R10 f empty/full/valid", {f_empty, f_full, f_valid}, 3'b100);
        chk("R10 s empty/full/valid", {s_empty, s_full, s_valid}, 3'b100);
    endtask

    task automatic t_fall_through();
        f_wr = 1'b1; f_wd = 8'hA5; tick(); f_wr = 1'b0;
        chk("R1 not yet shown", {f_valid, f_empty}, 2'b01);
        tick();
        chk("R1 shown without rd_en", {f_valid, f_q}, {1'b1, 8'hA5});
        chk("R6 empty tracks valid", f_empty, 1'b0);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R11 held while idle", {f_valid, f_q}, {1'b1, 8'hA5});
        end
        f_rd = 1'b1; tick(); f_rd = 1'b0;
        chk("R4 last word taken", {f_valid, f_empty}, 2'b01);
    endtask

    task automatic t_std_first();
        s_wr = 1'b1; s_wd = 8'h3C; tick(); s_wr = 1'b0;
        chk("R2 stored, not shown", {s_valid, s_empty}, 2'b00);
        tick(); tick();
        chk("R2 still not shown", s_valid, 1'b0);
        s_fetch("R3 fetch one cycle later", 8'h3C);
        chk("R6 empty after fetch", s_empty, 1'b1);
        tick();
        chk("R3 valid lasts one cycle", s_valid, 1'b0);
    endtask

    task automatic t_fill_drain();
        for (int i = 0; i <= DP; i++) begin
            f_wr = 1'b1; f_wd = DW'(8'h10 + i); tick();
        end
        f_wr = 1'b0;
        chk("R7 f full", f_full, 1'b1);
        f_wr = 1'b1; f_wd = 8'hEE; tick(); f_wr = 1'b0;
        chk("R7 f full after dropped write", f_full, 1'b1);
        for (int i = 0; i <= DP; i++) begin
            f_take("R5 f order", DW'(8'h10 + i));
        end
        chk("R7 f no extra word", {f_valid, f_empty}, 2'b01);

        for (int i = 0; i < DP; i++) begin
            s_wr = 1'b1; s_wd = DW'(8'h20 + i); tick();
        end
        s_wr = 1'b0;
        chk("R7 s full", s_full, 1'b1);
        s_wr = 1'b1; s_wd = 8'hEE; tick(); s_wr = 1'b0;
        for (int i = 0; i < DP; i++) begin
            s_fetch("R5 s order", DW'(8'h20 + i));
        end
        s_rd = 1'b1; tick(); s_rd = 1'b0;
        chk("R8 s read on empty ignored", {s_valid, s_empty}, 2'b01);
    endtask

    task automatic t_empty_read();
        f_rd = 1'b1; tick(); tick(); f_rd = 1'b0;
        chk("R8 f read on empty ignored", {f_valid, f_empty}, 2'b01);
        f_wr = 1'b1; f_wd = 8'h5A; tick(); f_wr = 1'b0; tick();
        f_take("R8 f traffic after empty read", 8'h5A);
        s_wr = 1'b1; s_wd = 8'h6B; tick(); s_wr = 1'b0;
        s_fetch("R8 s traffic after empty read", 8'h6B);
    endtask

    task automatic t_simul();
        f_wr = 1'b1; f_wd = 8'h30; tick(); f_wd = 8'h31; tick();
        f_wd = 8'h32; f_rd = 1'b1; tick(); f_wr = 1'b0; f_rd = 1'b0;
        chk("R9 f next word at once", {f_valid, f_q}, {1'b1, 8'h31});
        chk("R9 f flags", {f_empty, f_full}, 2'b00);
        f_take("R9 f drain", 8'h31);
        f_take("R9 f drain", 8'h32);
        chk("R9 f drained", f_empty, 1'b1);

        s_wr = 1'b1; s_wd = 8'h40; tick(); s_wd = 8'h41; tick();
        s_wd = 8'h42; s_rd = 1'b1; tick(); s_wr = 1'b0; s_rd = 1'b0;
        chk("R9 s fetched word", {s_valid, s_q}, {1'b1, 8'h40});
        chk("R9 s flags", {s_empty, s_full}, 2'b00);
        s_fetch("R9 s drain", 8'h41);
        s_fetch("R9 s drain", 8'h42);
        chk("R9 s drained", s_empty, 1'b1);
    endtask

    task automatic t_reset_flush();
        f_wr = 1'b1; s_wr = 1'b1; f_wd = 8'h77; s_wd = 8'h77; tick(); tick();
        f_wr = 1'b0; s_wr = 1'b0;
        rst = 1'b1; tick(); rst = 1'b0;
        t_reset_state();
        tick(); tick();
        chk("R10 f nothing falls through", {f_valid, f_empty}, 2'b01);
        s_rd = 1'b1; tick(); s_rd = 1'b0;
        chk("R10 s contents discarded", s_valid, 1'b0);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tick(); tick(); rst = 1'b0;
        t_reset_state();
        t_fall_through();
        t_std_first();
        t_fill_drain();
        t_empty_read();
        t_simul();
        t_reset_flush();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule